// File: doc/BRIEF.md
# Serial Audio Output Port with Start-up Muting

This block sends a stereo pair of 16-bit two's-complement samples out of a single serial data pin. It works as a slave: the bit clock and the frame (word-select) clock both come from outside. A static format input selects one of two framings. In the left-justified framing, a high word-select marks the left channel and the MSB appears in the bit slot that starts at the word-select edge. In the I2S framing, a low word-select marks the left channel and the MSB appears one bit clock after the edge. Any frame of at least 32 bit clocks works, and both 32 and 64 clocks per frame are supported. Bit slots after the LSB are sent as zero.

The block also sequences start-up after power-down. While the active-low reset/power-down input is low, the output is zero. After release, nothing happens until the first rising word-select edge. Every word then stays at zero until a fixed number of rising word-select edges (4128 by default) have been counted. Only after that are live samples sent. The bit clock and word-select are oversampled by the system clock. The serial output is registered one system clock after a detected falling bit-clock edge.

Top module: `serial_audio_tx`

## Requirements
- R1: Words are sent MSB first. The serial output changes only in the system-clock cycle that follows a detected falling edge of the bit clock, and at most once per bit-clock period.
- R2: With `fmt_sel` = 0 (left-justified), `lrck` = 1 is the left channel. Bit 15 of a word is sent in the bit slot that begins at the falling bit-clock edge where `lrck` changes.
- R3: With `fmt_sel` = 1 (I2S), `lrck` = 0 is the left channel. Bit 15 is sent one slot after the `lrck` change. At 32 bit clocks per frame, the previous word's bit 0 occupies the slot at the `lrck` change.
- R4: The slot count per half frame follows `lrck` alone. Frames of 32 and 64 bit clocks need no configuration.
- R5: While `rst_n` is low, `sdto` is 0 from the next system clock on.
- R6: A word whose first slot falls before the count of rising `lrck` edges since reset reaches INIT_FRAMES is sent as all zeros. The count includes the edge at that slot.
- R7: Slots after bit 0 of a word, up to the start of the next word, are sent as 0.
- R8: The left/right sample pair is captured at the falling bit-clock edge where `lrck` moves to the left-channel level. Later changes to `smp_left` or `smp_right` do not alter that frame.
- R9: After reset release, `sdto` stays 0 until the first rising `lrck` edge starts the frame timing.
- R10: `sdto` is constant between consecutive falling bit-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst_n | input | 1 | Synchronous active-low reset and power-down |
| fmt_sel | input | 1 | Framing select: 0 left-justified, 1 I2S (static) |
| bclk | input | 1 | Bit clock from the external master |
| lrck | input | 1 | Word-select / frame clock from the external master |
| smp_left | input | 16 | Left-channel sample, two's complement |
| smp_right | input | 16 | Right-channel sample, two's complement |
| sdto | output | 1 | Serial data out |

## Verification
The bench targets the boundary where muting ends. A counter that is off by one frame releases live data one word early or one word late; at 32 clocks per frame in I2S framing, an error here also shows up as a stray or missing LSB in the first slot of the following half frame. It runs both framings at both frame lengths. A design with the one-slot I2S delay applied to the wrong format, or with the wrong channel polarity, swaps or shifts every word. A design that does not zero-fill the trailing slots fails at 64 clocks per frame. The bench also changes the sample inputs partway through each frame, which exposes a design that reads the samples live instead of holding the captured pair. Finally, it asserts reset in the middle of a live frame, which catches a sequencer that does not restart its count.

// File: rtl/satx_pkg.sv
// Shared types for the serial audio output port.
package satx_pkg;

    // Framing selection; the encoding matches the fmt_sel pin.
    typedef enum logic {
        FMT_LEFT_JUST = 1'b0,
        FMT_I2S       = 1'b1
    } frame_fmt_e;

endpackage

// File: rtl/satx_edges.sv
// Edge finder for the serial clocks.
// Compares the bit clock with its value one system clock earlier to find
// falling edges. Records the word-select level at each falling edge, so a
// word-select change is reported exactly at the falling edge it follows.
// Assumes bclk and lrck are already synchronous to clk and that each bclk
// level lasts at least one clk period.
module satx_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic lrck,
    output logic bclk_fall,
    output logic lrck_edge,
    output logic lrck_rise
);

    logic bclk_q;
    logic lrck_last_q;

    // Keep the previous bit clock and the word-select level at the last fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q      <= 1'b0;
            lrck_last_q <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (bclk_fall) begin
                lrck_last_q <= lrck;
            end
        end
    end

    assign bclk_fall = bclk_q & ~bclk;
    assign lrck_edge = bclk_fall & (lrck ^ lrck_last_q);
    assign lrck_rise = lrck_edge & lrck;

endmodule

// File: rtl/satx_init_seq.sv
// Start-up sequencer.
// Counts rising word-select edges after reset and saturates at INIT_FRAMES.
// Reports whether the frame timing has started, whether the output is still
// muted, and whether a word that begins in this cycle may carry live data.
// Assumes lrck_rise is a single-cycle pulse.
module satx_init_seq #(
    parameter int INIT_FRAMES = 4128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lrck_rise,
    output logic started,
    output logic started_now,
    output logic mute,
    output logic live_now
);

    localparam int CNT_W = $clog2(INIT_FRAMES + 1);
    localparam logic [CNT_W:0] LIMIT = (CNT_W + 1)'(INIT_FRAMES);

    logic [CNT_W-1:0] cnt_q;
    logic             started_q;
    logic [CNT_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + {{CNT_W{1'b0}}, lrck_rise};

    // Count frames until the limit and mark the first frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            started_q <= 1'b0;
        end else if (lrck_rise) begin
            started_q <= 1'b1;
            if ({1'b0, cnt_q} < LIMIT) begin
                cnt_q <= cnt_next[CNT_W-1:0];
            end
        end
    end

    assign started     = started_q;
    assign started_now = started_q | lrck_rise;
    assign mute        = ({1'b0, cnt_q} < LIMIT);
    assign live_now    = (cnt_next >= LIMIT);

endmodule

// File: rtl/satx_shifter.sv
// Word loader and serial shifter.
// Captures the sample pair when word-select moves to the left level. At
// each word start, loads the word for the current channel (or zero while
// muted). Shifts one bit per falling bit-clock edge and fills with zeros
// after the LSB. In I2S framing, a word starts one fall after the edge.
// Assumes fmt is static while out of reset.
module satx_shifter
    import satx_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  frame_fmt_e          fmt,
    input  logic                lrck,
    input  logic                bclk_fall,
    input  logic                lrck_edge,
    input  logic                started_now,
    input  logic                live_now,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                sdto
);

    logic                pend_q;
    logic [SAMPLE_W-1:0] lat_l_q;
    logic [SAMPLE_W-1:0] lat_r_q;
    logic [SAMPLE_W-1:0] shreg_q;
    logic                sdto_q;

    logic                left_lvl;
    logic                on_left;
    logic                latch_now;
    logic                word_start;
    logic [SAMPLE_W-1:0] src_word;
    logic [SAMPLE_W-1:0] load_word;

    // Decode channel, capture and word-start conditions.
    always_comb begin
        left_lvl   = (fmt == FMT_LEFT_JUST);
        on_left    = (lrck == left_lvl);
        latch_now  = lrck_edge & started_now & on_left;
        word_start = bclk_fall & started_now &
                     ((fmt == FMT_I2S) ? pend_q : lrck_edge);
        src_word   = on_left ? (latch_now ? smp_left : lat_l_q) : lat_r_q;
        load_word  = live_now ? src_word : '0;
    end

    // Hold the captured pair and shift the current word out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            lat_l_q <= '0;
            lat_r_q <= '0;
            shreg_q <= '0;
            sdto_q  <= 1'b0;
        end else begin
            if (latch_now) begin
                lat_l_q <= smp_left;
                lat_r_q <= smp_right;
            end
            if (bclk_fall) begin
                pend_q <= (fmt == FMT_I2S) & lrck_edge & started_now;
                if (word_start) begin
                    sdto_q  <= load_word[SAMPLE_W-1];
                    shreg_q <= {load_word[SAMPLE_W-2:0], 1'b0};
                end else begin
                    sdto_q  <= shreg_q[SAMPLE_W-1];
                    shreg_q <= {shreg_q[SAMPLE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign sdto = sdto_q;

endmodule

// File: rtl/serial_audio_tx.sv
// Slave serial audio output port with start-up muting.
// Connects the clock-edge finder, the start-up sequencer and the shifter.
// Assumes bclk and lrck are synchronous to clk and fmt_sel is static.
module serial_audio_tx
    import satx_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int INIT_FRAMES = 4128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_sel,
    input  logic                bclk,
    input  logic                lrck,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                sdto
);

    logic       bclk_fall;
    logic       lrck_edge;
    logic       lrck_rise;
    logic       started;
    logic       started_now;
    logic       mute;
    logic       live_now;
    frame_fmt_e fmt;

    assign fmt = frame_fmt_e'(fmt_sel);

    satx_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .lrck      (lrck),
        .bclk_fall (bclk_fall),
        .lrck_edge (lrck_edge),
        .lrck_rise (lrck_rise)
    );

    satx_init_seq #(.INIT_FRAMES(INIT_FRAMES)) u_init (
        .clk         (clk),
        .rst_n       (rst_n),
        .lrck_rise   (lrck_rise),
        .started     (started),
        .started_now (started_now),
        .mute        (mute),
        .live_now    (live_now)
    );

    satx_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt         (fmt),
        .lrck        (lrck),
        .bclk_fall   (bclk_fall),
        .lrck_edge   (lrck_edge),
        .started_now (started_now),
        .live_now    (live_now),
        .smp_left    (smp_left),
        .smp_right   (smp_right),
        .sdto        (sdto)
    );

endmodule

// File: rtl/serial_audio_tx_checker.sv
// Timing properties of the serial audio output port. Attached by bind.
module serial_audio_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic sdto,
    input logic bclk_fall,
    input logic started,
    input logic mute
);

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> !sdto); // R5

    AST_CHANGE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdto) |-> $past(bclk_fall)); // R10

    AST_MUTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mute |-> !sdto); // R6

    AST_IDLE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> !sdto); // R9

endmodule

bind serial_audio_tx serial_audio_tx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdto      (sdto),
    .bclk_fall (bclk_fall),
    .started   (started),
    .mute      (mute)
);

// File: tb/serial_audio_tx_bench.sv
// Bench: drives the serial clocks and predicts every output bit with a
// behavioural slot/queue model; compares on every system clock.
module serial_audio_tx_bench;

    localparam int SW     = 16;
    localparam int B_INIT = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fmt_sel = 1'b0;
    logic          bclk = 1'b1;
    logic          lrck = 1'b0;
    logic [SW-1:0] smp_left = '0;
    logic [SW-1:0] smp_right = '0;
    logic          sdto;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    logic  exp_bit = 1'b0;
    string exp_tag = "R5";

    int            m_rises;
    bit            m_started, m_pend, m_prev_lv, m_muted;
    logic [SW-1:0] m_lat_l, m_lat_r;
    bit            m_q[$];

    always #10 clk = ~clk;

    serial_audio_tx #(.SAMPLE_W(SW), .INIT_FRAMES(B_INIT)) u_serial_audio_tx (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bclk(bclk), .lrck(lrck),
        .smp_left(smp_left), .smp_right(smp_right), .sdto(sdto)
    );

    task automatic check(input bit ok, input string tag, input logic act, input logic expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: sdto=%0b expected %0b at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic model_reset();
        m_rises = 0; m_started = 0; m_pend = 0; m_prev_lv = 0; m_muted = 1;
        m_lat_l = '0; m_lat_r = '0; m_q.delete();
    endtask

    // Predict the bit sent after one falling bit-clock edge.
    task automatic model_fall(input bit lv);
        bit            edge_e, left_lv, start;
        logic [SW-1:0] w;
        edge_e    = (lv != m_prev_lv);
        m_prev_lv = lv;
        if (edge_e && lv) begin m_rises++; m_started = 1; end
        left_lv = (fmt_sel == 1'b0);
        start   = m_started && (fmt_sel ? m_pend : edge_e);
        m_pend  = fmt_sel && edge_e && m_started;
        if (m_started && edge_e && lv == left_lv) begin  // R8 capture point
            m_lat_l = smp_left;
            m_lat_r = smp_right;
        end
        if (start) begin
            w       = (lv == left_lv) ? m_lat_l : m_lat_r;
            m_muted = (m_rises < B_INIT);
            if (m_muted) w = '0;
            m_q.delete();
            for (int i = SW - 1; i >= 0; i--) m_q.push_back(w[i]);
        end
        if (!m_started) begin
            exp_bit = 1'b0; exp_tag = "R9";
        end else if (m_q.size() > 0) begin
            exp_bit = m_q.pop_front();
            exp_tag = m_muted ? "R6" : (fmt_sel ? "R3/R1/R8" : "R2/R1/R8");
        end else begin
            exp_bit = 1'b0; exp_tag = "R7/R4";
        end
    endtask

    // One bit slot: bclk low for two clocks, high for two.
    task automatic slot(input bit lv);
        @(negedge clk);
        bclk = 1'b0;
        lrck = lv;
        if (rst_n) model_fall(lv);
        else begin exp_bit = 1'b0; exp_tag = "R5"; end
        @(negedge clk);
        @(negedge clk);
        bclk = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [SW-1:0] pat(input int i, input bit right);
        case (i % 5)
            0: pat = right ? 16'h7FFF : 16'h8000;
            1: pat = right ? 16'h0001 : 16'hFFFF;
            2: pat = right ? 16'h3C5A : 16'hA5C3;
            default: pat = SW'(32'h1357 * (i + 1) + (right ? 32'h0F0F : 32'h0));
        endcase
    endfunction

    // One frame; the sample inputs are disturbed after capture (R8).
    task automatic frame(input int half, input logic [SW-1:0] l, input logic [SW-1:0] r);
        bit left_lv;
        left_lv   = (fmt_sel == 1'b0);
        smp_left  = l;
        smp_right = r;
        for (int k = 0; k < half; k++) begin
            slot(left_lv);
            if (k == 2) begin smp_left = ~l; smp_right = l ^ r; end
        end
        for (int k = 0; k < half; k++) slot(!left_lv);
    endtask

    // Reset (R5), select a format, then stream frames (R4: half = 16 or 32).
    task automatic run_mode(input bit fmt, input int half, input int nframes);
        @(negedge clk);
        rst_n = 1'b0;
        exp_bit = 1'b0; exp_tag = "R5";
        fmt_sel = fmt;
        lrck = 1'b0;
        for (int k = 0; k < 3; k++) slot(1'b0);
        model_reset();
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) slot(1'b0);  // R9: no frame start yet
        for (int f = 0; f < nframes; f++) frame(half, pat(f, 0), pat(f, 1));
    endtask

    always @(posedge clk) begin
        #5;
        if (!done) check(sdto === exp_bit, {exp_tag, "/R10"}, sdto, exp_bit);
    end

    initial begin
        model_reset();
        run_mode(1'b0, 16, 10);   // R2 at 32 bit clocks per frame
        run_mode(1'b0, 32, 9);    // R2 R7 at 64
        run_mode(1'b1, 16, 10);   // R3 at 32, LSB carried into next half
        run_mode(1'b1, 32, 9);    // R3 R7 at 64
        for (int k = 0; k < 5; k++) slot(1'b0);  // partial frame, then reset (R5 R6)
        run_mode(1'b0, 16, 9);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule